// File: doc/BRIEF.md
# Burst-Capable Time Shadow Buffer

This block sits between a byte-level serial front end and a set of live timekeeping counters. It also holds a small RAM. A transaction is framed by a chip-enable. When the enable rises, the block takes a snapshot of the live time registers into a user-side shadow copy. Every read in that transaction is served from the snapshot, so a multi-byte read stays coherent while the counters keep ticking. Writes to time registers land in the shadow. They reach the counters only when the enable falls. At that point the block issues a one-cycle load mask and a load bus, plus a clear pulse for the sub-second prescaler whenever the seconds register is loaded.

A command strobe selects the address space (clock or RAM) and a 5-bit address. The all-ones address selects burst mode. A burst starts at address 0, and the pointer advances after every data byte. For a clock-space burst write, data is committed only if all eight time registers were written. RAM bytes are stored as each one arrives, so a partial RAM burst keeps every byte it delivered. The serial shifting and the counting itself are handled elsewhere.

Top module: `shbuf_top`

## Requirements
- R1: A command with address 31 (all ones) sets burst mode with the pointer at 0. In burst mode each data read or write strobe advances the pointer by one, saturating at 31. In single mode the pointer stays at the commanded address.
- R2: The clock space stores addresses 0 to 7 only, and reads of clock addresses 8 to 31 return 0. The RAM space stores addresses 0 to 30; a write to RAM address 31 is dropped and a read of it returns 0.
- R3: A `ce_rise` pulse copies `live_time` into the shadow copy and clears the record of written registers.
- R4: One cycle after a `ce_fall` pulse, `load_en` shows for exactly one cycle the set of clock registers written since the last `ce_rise` (bit i means register i). With no writes, `load_en` stays 0.
- R5: After a clock-space burst, `load_en` is 0xFF if all eight registers were written, and 0 if any were not.
- R6: A RAM write strobe stores the byte at once. Every byte of a partial RAM burst is kept and reads back later.
- R7: `presc_clr` pulses in the same cycle as `load_en`, only when `load_en` bit 0 (the seconds register) is set.
- R8: Clock-space reads return the shadow value (the snapshot, or a byte written earlier in the same transaction), not later changes of `live_time`.
- R9: `load_bus` carries the full shadow, with register i in bits [8i+7:8i]. It holds its value between commits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ce_rise | input | 1 | One-cycle pulse: transaction start |
| ce_fall | input | 1 | One-cycle pulse: transaction end |
| cmd_stb | input | 1 | Command byte received |
| cmd_ram | input | 1 | Command space: 1 = RAM, 0 = clock |
| cmd_addr | input | 5 | Command address; 31 = burst |
| wr_stb | input | 1 | Data byte write strobe |
| wr_data | input | 8 | Data byte to write |
| rd_stb | input | 1 | Data byte consumed by the reader |
| rd_data | output | 8 | Byte at the current pointer |
| live_time | input | 64 | Live counter values, register i at [8i+7:8i] |
| load_en | output | 8 | One-cycle per-register load mask |
| load_bus | output | 64 | Shadow contents toward the counters |
| presc_clr | output | 1 | Prescaler clear on a seconds load |

## Verification
The snapshot is tested by changing `live_time` after `ce_rise` and then reading. This separates a shadow-served read from one that passes the live value straight through. Single writes to the seconds register and to another register separate per-register masking, and whether the prescaler clear is tied to bit 0. Full and partial clock bursts tell the all-or-nothing commit apart from per-byte commit. A partial RAM burst, followed by a read-back in a later transaction, shows that RAM bytes are kept one by one. Reads past the last stored address in each space check that unimplemented locations return 0.

// File: rtl/shbuf_pkg.sv
package shbuf_pkg;
  typedef enum logic {SP_CLK = 1'b0, SP_RAM = 1'b1} space_e;

  // all-ones address selects burst
  function automatic logic is_burst_addr(input logic [4:0] a);
    return &a;
  endfunction

  // clock-space burst commits only when every register is dirty
  function automatic logic [7:0] commit_mask(input logic burst_clk, input logic [7:0] dirty);
    return (burst_clk && !(&dirty)) ? 8'h00 : dirty;
  endfunction
endpackage

// File: rtl/shbuf_addr_ctrl.sv
module shbuf_addr_ctrl
  import shbuf_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_rise,
  input  logic              cmd_stb,
  input  logic              cmd_ram,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic              step,
  output space_e            space,
  output logic              burst,
  output logic [ADDR_W-1:0] ptr
);
  localparam logic [ADDR_W-1:0] TOP = '1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      space <= SP_CLK;
      burst <= 1'b0;
      ptr   <= '0;
    end else if (ce_rise) begin
      space <= SP_CLK;
      burst <= 1'b0;
      ptr   <= '0;
    end else if (cmd_stb) begin
      space <= cmd_ram ? SP_RAM : SP_CLK;
      burst <= (cmd_addr == TOP);
      ptr   <= (cmd_addr == TOP) ? '0 : cmd_addr;
    end else if (step && burst && ptr != TOP) begin
      ptr <= ptr + 1'b1;
    end
  end
endmodule

// File: rtl/shbuf_clk_bank.sv
module shbuf_clk_bank #(
  parameter int NUM_CLK = 8,
  parameter int DATA_W  = 8,
  localparam int CI_W   = $clog2(NUM_CLK)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      snap,
  input  logic [NUM_CLK*DATA_W-1:0] live_flat,
  input  logic                      wr_en,
  input  logic [CI_W-1:0]           wr_idx,
  input  logic [DATA_W-1:0]         wr_data,
  output logic [NUM_CLK*DATA_W-1:0] shadow_flat,
  output logic [NUM_CLK-1:0]        dirty
);
  for (genvar i = 0; i < NUM_CLK; i++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        shadow_flat[i*DATA_W +: DATA_W] <= '0;
        dirty[i]                        <= 1'b0;
      end else if (snap) begin
        shadow_flat[i*DATA_W +: DATA_W] <= live_flat[i*DATA_W +: DATA_W];
        dirty[i]                        <= 1'b0;
      end else if (wr_en && wr_idx == CI_W'(i)) begin
        shadow_flat[i*DATA_W +: DATA_W] <= wr_data;
        dirty[i]                        <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/shbuf_ram_bank.sv
module shbuf_ram_bank #(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 8,
  localparam int DEPTH = (1 << ADDR_W) - 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data
);
  localparam logic [ADDR_W-1:0] LIM = ADDR_W'(DEPTH);
  logic [DATA_W-1:0] mem [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_byte
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                             mem[i] <= '0;
      else if (wr_en && addr == ADDR_W'(i))   mem[i] <= wr_data;
    end
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < DEPTH; i++)
      if (addr == ADDR_W'(i)) rd_data = mem[i];
    if (addr == LIM) rd_data = '0;
  end
endmodule

// File: rtl/shbuf_commit.sv
module shbuf_commit
  import shbuf_pkg::*;
#(
  parameter int NUM_CLK = 8,
  parameter int DATA_W  = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      ce_fall,
  input  logic                      burst_clk,
  input  logic [NUM_CLK-1:0]        dirty,
  input  logic [NUM_CLK*DATA_W-1:0] shadow_flat,
  output logic [NUM_CLK-1:0]        load_en,
  output logic [NUM_CLK*DATA_W-1:0] load_bus,
  output logic                      presc_clr
);
  logic [NUM_CLK-1:0] mask;
  assign mask = (burst_clk && !(&dirty)) ? '0 : dirty;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      load_en   <= '0;
      load_bus  <= '0;
      presc_clr <= 1'b0;
    end else begin
      load_en   <= ce_fall ? mask : '0;
      presc_clr <= ce_fall && mask[0];
      if (ce_fall) load_bus <= shadow_flat;
    end
  end
endmodule

// File: rtl/shbuf_top.sv
module shbuf_top
  import shbuf_pkg::*;
#(
  parameter int NUM_CLK = 8,
  parameter int DATA_W  = 8,
  parameter int ADDR_W  = 5
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      ce_rise,
  input  logic                      ce_fall,
  input  logic                      cmd_stb,
  input  logic                      cmd_ram,
  input  logic [ADDR_W-1:0]         cmd_addr,
  input  logic                      wr_stb,
  input  logic [DATA_W-1:0]         wr_data,
  input  logic                      rd_stb,
  output logic [DATA_W-1:0]         rd_data,
  input  logic [NUM_CLK*DATA_W-1:0] live_time,
  output logic [NUM_CLK-1:0]        load_en,
  output logic [NUM_CLK*DATA_W-1:0] load_bus,
  output logic                      presc_clr
);
  localparam int CI_W = $clog2(NUM_CLK);
  localparam logic [ADDR_W-1:0] CLK_LIM = ADDR_W'(NUM_CLK);

  space_e                    space;
  logic                      burst;
  logic [ADDR_W-1:0]         ptr;
  logic [NUM_CLK*DATA_W-1:0] shadow_flat;
  logic [NUM_CLK-1:0]        dirty;
  logic [DATA_W-1:0]         ram_rd;
  logic [DATA_W-1:0]         sh_arr [NUM_CLK];

  // named internal events
  logic ev_snap, ev_commit, ev_wr_clk, ev_wr_ram, in_clk, burst_clk;
  assign ev_snap   = ce_rise;
  assign ev_commit = ce_fall;
  assign in_clk    = ptr < CLK_LIM;
  assign ev_wr_clk = wr_stb && space == SP_CLK && in_clk;
  assign ev_wr_ram = wr_stb && space == SP_RAM;
  assign burst_clk = burst && space == SP_CLK;

  shbuf_addr_ctrl #(.ADDR_W(ADDR_W)) u_addr (
    .clk(clk), .rst_n(rst_n), .ce_rise(ce_rise), .cmd_stb(cmd_stb),
    .cmd_ram(cmd_ram), .cmd_addr(cmd_addr), .step(wr_stb | rd_stb),
    .space(space), .burst(burst), .ptr(ptr)
  );

  shbuf_clk_bank #(.NUM_CLK(NUM_CLK), .DATA_W(DATA_W)) u_clk (
    .clk(clk), .rst_n(rst_n), .snap(ev_snap), .live_flat(live_time),
    .wr_en(ev_wr_clk), .wr_idx(ptr[CI_W-1:0]), .wr_data(wr_data),
    .shadow_flat(shadow_flat), .dirty(dirty)
  );

  shbuf_ram_bank #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ram (
    .clk(clk), .rst_n(rst_n), .wr_en(ev_wr_ram), .addr(ptr),
    .wr_data(wr_data), .rd_data(ram_rd)
  );

  shbuf_commit #(.NUM_CLK(NUM_CLK), .DATA_W(DATA_W)) u_commit (
    .clk(clk), .rst_n(rst_n), .ce_fall(ev_commit), .burst_clk(burst_clk),
    .dirty(dirty), .shadow_flat(shadow_flat), .load_en(load_en),
    .load_bus(load_bus), .presc_clr(presc_clr)
  );

  for (genvar i = 0; i < NUM_CLK; i++) begin : g_unpack
    assign sh_arr[i] = shadow_flat[i*DATA_W +: DATA_W];
  end

  always_comb begin
    if (space == SP_CLK) rd_data = in_clk ? sh_arr[ptr[CI_W-1:0]] : '0;
    else                 rd_data = ram_rd;
  end
endmodule

// File: rtl/shbuf_chk.sv
module shbuf_chk
  import shbuf_pkg::*;
#(
  parameter int NUM_CLK = 8,
  parameter int DATA_W  = 8,
  parameter int ADDR_W  = 5
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      ce_rise,
  input logic                      ce_fall,
  input logic                      cmd_stb,
  input logic [ADDR_W-1:0]         cmd_addr,
  input logic [DATA_W-1:0]         rd_data,
  input logic [NUM_CLK*DATA_W-1:0] live_time,
  input logic [NUM_CLK*DATA_W-1:0] shadow_flat,
  input logic [NUM_CLK-1:0]        dirty,
  input logic [NUM_CLK-1:0]        load_en,
  input logic                      presc_clr,
  input logic                      burst,
  input space_e                    space,
  input logic [ADDR_W-1:0]         ptr
);
  AST_BURST_START: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_stb && !ce_rise && (&cmd_addr)) |=> (burst && ptr == '0)); // R1
  AST_UNIMPL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (space == SP_CLK && ptr >= ADDR_W'(NUM_CLK)) |-> rd_data == '0); // R2
  AST_SNAP_COPY: assert property (@(posedge clk) disable iff (!rst_n)
    ce_rise |=> shadow_flat == $past(live_time)); // R3
  AST_DIRTY_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    ce_rise |=> dirty == '0); // R3
  AST_LOAD_ONLY_AFTER_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    (load_en != '0) |-> $past(ce_fall)); // R4
  AST_PARTIAL_BURST_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (ce_fall && burst && space == SP_CLK && !(&dirty)) |=> load_en == '0); // R5
  AST_PRESC_WITH_SEC: assert property (@(posedge clk) disable iff (!rst_n)
    presc_clr |-> load_en[0]); // R7
endmodule

bind shbuf_top shbuf_chk #(.NUM_CLK(NUM_CLK), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ce_rise(ce_rise), .ce_fall(ce_fall),
  .cmd_stb(cmd_stb), .cmd_addr(cmd_addr), .rd_data(rd_data),
  .live_time(live_time), .shadow_flat(shadow_flat), .dirty(dirty),
  .load_en(load_en), .presc_clr(presc_clr), .burst(burst),
  .space(space), .ptr(ptr)
);

// File: tb/shbuf_top_tb.sv
module shbuf_top_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ce_rise = 0, ce_fall = 0, cmd_stb = 0, cmd_ram = 0;
  logic [4:0]  cmd_addr = '0;
  logic        wr_stb = 0, rd_stb = 0;
  logic [7:0]  wr_data = '0;
  logic [7:0]  rd_data;
  logic [63:0] live_time = '0;
  logic [7:0]  load_en;
  logic [63:0] load_bus;
  logic        presc_clr;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  shbuf_top u_dut (
    .clk(clk), .rst_n(rst_n), .ce_rise(ce_rise), .ce_fall(ce_fall),
    .cmd_stb(cmd_stb), .cmd_ram(cmd_ram), .cmd_addr(cmd_addr),
    .wr_stb(wr_stb), .wr_data(wr_data), .rd_stb(rd_stb), .rd_data(rd_data),
    .live_time(live_time), .load_en(load_en), .load_bus(load_bus),
    .presc_clr(presc_clr)
  );

  function automatic logic [63:0] pat(input logic [7:0] base);
    logic [63:0] v;
    for (int i = 0; i < 8; i++) v[i*8 +: 8] = base + 8'(i);
    return v;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic t_rise();
    @(negedge clk) ce_rise = 1; @(negedge clk) ce_rise = 0;
  endtask
  task automatic t_fall();   // returns at negedge where load outputs are visible
    @(negedge clk) ce_fall = 1; @(negedge clk) ce_fall = 0;
  endtask
  task automatic t_cmd(input bit ram, input logic [4:0] a);
    @(negedge clk) begin cmd_stb = 1; cmd_ram = ram; cmd_addr = a; end
    @(negedge clk) cmd_stb = 0;
  endtask
  task automatic t_wr(input logic [7:0] d);
    @(negedge clk) begin wr_stb = 1; wr_data = d; end
    @(negedge clk) wr_stb = 0;
  endtask
  task automatic t_rd();
    @(negedge clk) rd_stb = 1; @(negedge clk) rd_stb = 0;
  endtask

  task automatic sc_reset();
    chk(rd_data == 0, "R2 reset rd_data", rd_data, 0);
    chk(load_en == 0 && presc_clr == 0, "R4 reset load", load_en, 0);
  endtask

  task automatic sc_snapshot();
    live_time = pat(8'h10);
    t_rise();
    live_time = pat(8'h50);
    t_cmd(0, 5'd3);
    chk(rd_data == 8'h13, "R8 shadow read after live change", rd_data, 8'h13);
    t_fall();
    chk(load_en == 0, "R4 no writes no load", load_en, 0);
  endtask

  task automatic sc_single();
    logic [63:0] snap;
    live_time = pat(8'h20); snap = pat(8'h20);
    t_rise();
    t_cmd(0, 5'd2);
    t_wr(8'h45);
    chk(rd_data == 8'h45, "R8 read of written byte", rd_data, 8'h45);
    t_fall();
    chk(load_en == 8'b0000_0100, "R4 single write mask", load_en, 8'h04);
    chk(load_bus[23:16] == 8'h45 && load_bus[15:8] == snap[15:8], "R9 load_bus layout", load_bus, {snap[63:24], 8'h45, snap[15:0]});
    chk(presc_clr == 0, "R7 no clear without seconds", presc_clr, 0);
    @(negedge clk);
    chk(load_en == 0 && load_bus[23:16] == 8'h45, "R4 R9 pulse ends, bus held", {load_en, load_bus[23:16]}, {8'h00, 8'h45});
    t_rise();
    t_cmd(0, 5'd0);
    t_wr(8'h30);
    t_fall();
    chk(load_en == 8'h01 && presc_clr == 1, "R7 seconds load clears prescaler", {load_en, 7'd0, presc_clr}, {8'h01, 8'h01});
  endtask

  task automatic sc_burst_full();
    logic [63:0] exp;
    t_rise();
    t_cmd(0, 5'd31);
    for (int i = 0; i < 8; i++) begin t_wr(8'hA0 + 8'(i)); exp[i*8 +: 8] = 8'hA0 + 8'(i); end
    t_wr(8'hEE);
    t_fall();
    chk(load_en == 8'hFF, "R5 full clock burst commits", load_en, 8'hFF);
    chk(load_bus == exp, "R1 burst order into load_bus", load_bus, exp);
    chk(presc_clr == 1, "R7 burst clears prescaler", presc_clr, 1);
  endtask

  task automatic sc_burst_partial();
    t_rise();
    t_cmd(0, 5'd31);
    for (int i = 0; i < 5; i++) t_wr(8'h77);
    t_fall();
    chk(load_en == 0 && presc_clr == 0, "R5 partial clock burst dropped", load_en, 0);
  endtask

  task automatic sc_ram();
    t_rise();
    t_cmd(1, 5'd31);
    t_wr(8'h11); t_wr(8'h22); t_wr(8'h33);
    t_fall();
    chk(load_en == 0, "R6 RAM writes do not load clock", load_en, 0);
    t_rise();
    t_cmd(1, 5'd0);
    chk(rd_data == 8'h11, "R6 partial RAM burst byte 0", rd_data, 8'h11);
    t_cmd(1, 5'd2);
    chk(rd_data == 8'h33, "R6 partial RAM burst byte 2", rd_data, 8'h33);
    t_cmd(1, 5'd3);
    chk(rd_data == 8'h00, "R6 unwritten RAM byte", rd_data, 0);
    t_cmd(1, 5'd30);
    t_wr(8'h5A);
    chk(rd_data == 8'h5A, "R2 top RAM byte stored", rd_data, 8'h5A);
    t_fall();
    t_rise();
    t_cmd(1, 5'd31);  // burst mode, pointer 0
    for (int i = 0; i < 31; i++) t_rd();
    chk(rd_data == 8'h00, "R2 RAM address 31 reads zero", rd_data, 0);
    t_wr(8'hC3);      // pointer stays 31: dropped
    chk(rd_data == 8'h00, "R2 RAM address 31 write dropped", rd_data, 0);
    t_fall();
  endtask

  task automatic sc_burst_read();
    logic [63:0] v;
    bit ok;
    v = pat(8'h61); live_time = v;
    t_rise();
    live_time = pat(8'h90);
    t_cmd(0, 5'd31);
    ok = 1;
    for (int i = 0; i < 8; i++) begin
      if (rd_data != v[i*8 +: 8]) ok = 0;
      t_rd();
    end
    chk(ok, "R1 R3 burst read of snapshot", {56'd0, rd_data}, 0);
    chk(rd_data == 0, "R2 clock address 8 reads zero", rd_data, 0);
    t_cmd(0, 5'd12);
    chk(rd_data == 0, "R2 clock address 12 reads zero", rd_data, 0);
    t_cmd(0, 5'd4);
    t_rd();
    chk(rd_data == v[39:32], "R1 single mode pointer holds", rd_data, v[39:32]);
    t_fall();
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    sc_reset();
    sc_snapshot();
    sc_single();
    sc_burst_full();
    sc_burst_partial();
    sc_ram();
    sc_burst_read();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule